// File: doc/BRIEF.md
# Matrix Remap Index Generator

This block turns a plain vector loop into a walk over a small array of one, two or three dimensions. A 32-bit shape word sets the size of each dimension, the order in which the dimensions are nested, a count-down option for each dimension, a dimension that may be dropped from the result, and a constant offset. After a shape and a walk length are loaded, each accepted step moves the walk forward by one element. The block shows the element index for the current step and raises a one-cycle done pulse once the last step has been taken.

Each dimension has its own counter. A dimension's counter carries into the next dimension in the selected nesting order. The output index is built from the three coordinates using fixed x, y, z strides, so the nesting order changes the sequence in which indices appear but not how a coordinate maps to an index. Typical uses are matrix transpose and outer-product access patterns, and repeating or modulo index sequences.

Top module: `matrix_remap_gen`

## Requirements
- R1: After reset, `idx_valid`, `walk_done` and `shape_err` are all 0.
- R2: The size fields store the size minus one: x in bits 5..0, y in bits 11..6, z in bits 17..12. The index is x + y*SX + z*SX*SY, where SX and SY are the x and y sizes.
- R3: The order field in bits 20..18 sets which dimension varies fastest. Its values 0 to 5 give the orders (x,y,z), (x,z,y), (y,x,z), (y,z,x), (z,x,y) and (z,y,x), listed from fastest to slowest. Each dimension wraps from its size minus one back to 0, and the wrap carries into the next dimension in that order.
- R4: Bits 21, 22 and 23 make x, y and z count down. A dimension with its bit set starts at its size minus one and ends at 0.
- R5: The skip field in bits 29..28 drops a dimension from the index: 1 drops x, 2 drops y, 3 drops z, and 0 drops none. The kept dimensions take strides as if the dropped dimension were not there (skip x: y + z*SY; skip y: x + z*SX; skip z: x + y*SX).
- R6: The 4-bit offset in bits 27..24 is added to every index.
- R7: A shape word of all zeros gives an index equal to the step number.
- R8: The walk length is 1 to 127 steps. `walk_done` pulses for one cycle in the cycle after the last step is accepted, and `idx_valid` falls in that same cycle. A length of 0 leaves the block idle.
- R9: A word whose bits 31..30 are not 00, or whose order field is 6 or 7, sets `shape_err` and starts no walk. Loading a valid word clears `shape_err`.
- R10: `shape_load` restarts the walk from step 0 even in the middle of a walk, and it takes priority over `step` in the same cycle.
- R11: While `step` is low, the index and the walk position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shape_load | input | 1 | Loads the shape word and the length, then restarts the walk |
| shape_word | input | 32 | Shape configuration |
| walk_len | input | 7 | Number of steps in the walk |
| step | input | 1 | Moves the walk forward when `idx_valid` is high |
| idx_valid | output | 1 | A walk is in progress and `idx` is meaningful |
| idx | output | 19 | Remapped index for the current step |
| walk_done | output | 1 | One-cycle pulse after the final step |
| shape_err | output | 1 | The last loaded word is not a matrix shape |

## Verification
The hardest case to reach is a carry through all three counters, where both of the faster dimensions are at their last value in the selected nesting order. Counting down, the dropped dimension and the offset must all apply at that same moment. To reach it, the bench sweeps every order, every count-down combination and every skip value over two small non-square shapes. It also runs walks longer than the array, so the slowest counter wraps as well. A load in the middle of a walk, with `step` held high in the same cycle, tests that the restart takes priority.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int WORD_W = 32;
  localparam int DIM_W  = 6;
  localparam int NDIM   = 3;
  localparam int ORD_W  = 3;
  localparam int OFF_W  = 4;
  localparam int SKIP_W = 2;
  localparam int LEN_W  = 7;
  localparam int IDX_W  = NDIM * DIM_W + 1;

  typedef struct packed {
    logic [NDIM-1:0][DIM_W-1:0] dim_m1;
    logic [ORD_W-1:0]           order;
    logic [NDIM-1:0]            inv;
    logic [OFF_W-1:0]           offset;
    logic [SKIP_W-1:0]          skip;
    logic                       bypass;
  } shape_t;

  // Returns the dimension number that sits at nesting level pos (0 = fastest).
  function automatic logic [1:0] order_dim(input logic [ORD_W-1:0] sel, input int pos);
    logic [5:0] tab;
    case (sel)
      3'd0:    tab = {2'd2, 2'd1, 2'd0};
      3'd1:    tab = {2'd1, 2'd2, 2'd0};
      3'd2:    tab = {2'd2, 2'd0, 2'd1};
      3'd3:    tab = {2'd0, 2'd2, 2'd1};
      3'd4:    tab = {2'd1, 2'd0, 2'd2};
      default: tab = {2'd0, 2'd1, 2'd2};
    endcase
    return tab[pos*2 +: 2];
  endfunction

  // Builds the index from the coordinates: fixed strides over the kept dimensions.
  function automatic logic [IDX_W-1:0] fold_index(input shape_t s,
                                                  input logic [NDIM-1:0][DIM_W-1:0] c);
    logic [IDX_W-1:0] sx, sy, str_y, str_z, acc;
    logic kx, ky, kz;
    sx = IDX_W'(s.dim_m1[0]) + 1'b1;
    sy = IDX_W'(s.dim_m1[1]) + 1'b1;
    kx = (s.skip != 2'd1);
    ky = (s.skip != 2'd2);
    kz = (s.skip != 2'd3);
    str_y = kx ? sx : IDX_W'(1);
    str_z = str_y * (ky ? sy : IDX_W'(1));
    acc = IDX_W'(s.offset);
    if (kx) acc = acc + IDX_W'(c[0]);
    if (ky) acc = acc + IDX_W'(c[1]) * str_y;
    if (kz) acc = acc + IDX_W'(c[2]) * str_z;
    return acc;
  endfunction
endpackage

// File: rtl/remap_shape_decode.sv
module remap_shape_decode
  import remap_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output shape_t            shape,
  output logic              bad
);
  localparam int ORD_LO  = NDIM * DIM_W;
  localparam int INV_LO  = ORD_LO + ORD_W;
  localparam int OFF_LO  = INV_LO + NDIM;
  localparam int SKIP_LO = OFF_LO + OFF_W;
  localparam int MODE_LO = SKIP_LO + SKIP_W;

  always_comb begin
    for (int d = 0; d < NDIM; d++) shape.dim_m1[d] = word[d*DIM_W +: DIM_W];
    shape.order  = word[ORD_LO +: ORD_W];
    shape.inv    = word[INV_LO +: NDIM];
    shape.offset = word[OFF_LO +: OFF_W];
    shape.skip   = word[SKIP_LO +: SKIP_W];
    shape.bypass = (word == '0);
    bad = (word[WORD_W-1:MODE_LO] != '0) || (word[ORD_LO+1 +: 2] == 2'b11);
  end
endmodule

// File: rtl/remap_dim_counter.sv
module remap_dim_counter #(
  parameter int DIM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [DIM_W-1:0] size_m1,
  input  logic             invert,
  output logic [DIM_W-1:0] coord,
  output logic             at_end
);
  logic [DIM_W-1:0] ord_q;

  assign at_end = (ord_q == size_m1);
  assign coord  = invert ? (size_m1 - ord_q) : ord_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ord_q <= '0;
    else if (clr) ord_q <= '0;
    else if (inc) ord_q <= at_end ? '0 : ord_q + 1'b1;
  end
endmodule

// File: rtl/remap_index_unit.sv
module remap_index_unit
  import remap_pkg::*;
(
  input  shape_t                     shape,
  input  logic [NDIM-1:0][DIM_W-1:0] coord,
  input  logic [LEN_W-1:0]           step_cnt,
  output logic [IDX_W-1:0]           idx
);
  assign idx = shape.bypass ? IDX_W'(step_cnt) : fold_index(shape, coord);
endmodule

// File: rtl/matrix_remap_gen.sv
module matrix_remap_gen
  import remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shape_load,
  input  logic [WORD_W-1:0] shape_word,
  input  logic [LEN_W-1:0]  walk_len,
  input  logic              step,
  output logic              idx_valid,
  output logic [IDX_W-1:0]  idx,
  output logic              walk_done,
  output logic              shape_err
);
  shape_t                     dec_shape, shape_q;
  logic                       dec_bad;
  logic [LEN_W-1:0]           len_q, cnt_q;
  logic                       active_q, done_q, err_q;
  logic [NDIM-1:0][DIM_W-1:0] coord;
  logic [NDIM-1:0]            at_end, dim_inc;
  logic                       step_fire, last_fire, clr;

  remap_shape_decode u_dec (.word(shape_word), .shape(dec_shape), .bad(dec_bad));

  assign step_fire = step && active_q && !shape_load;
  assign last_fire = step_fire && (cnt_q == len_q - 1'b1);
  assign clr       = shape_load || last_fire;

  // Carry chain follows the selected nesting order.
  always_comb begin
    logic go;
    logic [1:0] d;
    dim_inc = '0;
    go = step_fire;
    for (int k = 0; k < NDIM; k++) begin
      d = order_dim(shape_q.order, k);
      dim_inc[d] = go;
      go = go && at_end[d];
    end
  end

  for (genvar g = 0; g < NDIM; g++) begin : g_dim
    remap_dim_counter #(.DIM_W(DIM_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(dim_inc[g]),
      .size_m1(shape_q.dim_m1[g]), .invert(shape_q.inv[g]),
      .coord(coord[g]), .at_end(at_end[g]));
  end

  remap_index_unit u_idx (.shape(shape_q), .coord(coord), .step_cnt(cnt_q), .idx(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q  <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (shape_load) begin
      shape_q  <= dec_shape;
      len_q    <= walk_len;
      cnt_q    <= '0;
      active_q <= !dec_bad && (walk_len != '0);
      done_q   <= 1'b0;
      err_q    <= dec_bad;
    end else begin
      done_q <= last_fire;
      if (last_fire) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else if (step_fire) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign idx_valid = active_q;
  assign walk_done = done_q;
  assign shape_err = err_q;
endmodule

// File: rtl/remap_chk.sv
module remap_chk
  import remap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             shape_load,
  input logic             step,
  input logic             idx_valid,
  input logic [IDX_W-1:0] idx,
  input logic             walk_done,
  input logic             shape_err,
  input logic             last_fire,
  input logic [LEN_W-1:0] cnt_q,
  input logic [LEN_W-1:0] len_q
);
  // R8
  last_step_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> walk_done);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> !idx_valid);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> (cnt_q < len_q));
  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shape_err |-> !idx_valid);
  // R10
  load_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shape_load |=> !walk_done);
  // R11
  hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && !step && !shape_load) |=> $stable(idx));
endmodule

bind matrix_remap_gen remap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shape_load(shape_load), .step(step),
  .idx_valid(idx_valid), .idx(idx), .walk_done(walk_done), .shape_err(shape_err),
  .last_fire(last_fire), .cnt_q(cnt_q), .len_q(len_q));

// File: tb/tb_matrix_remap_gen.sv
module tb_matrix_remap_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shape_load = 1'b0;
  logic [31:0] shape_word = '0;
  logic [6:0]  walk_len = '0;
  logic        step = 1'b0;
  logic        idx_valid, walk_done, shape_err;
  logic [18:0] idx;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  matrix_remap_gen dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int xs, int ys, int zs, int ord, int inv, int off, int skp);
    return {2'b00, 2'(skp), 4'(off), 3'(inv), 3'(ord), 6'(zs-1), 6'(ys-1), 6'(xs-1)};
  endfunction

  // Model: decompose the step number by mixed radix in nesting order.
  function automatic longint model(input logic [31:0] w, input int s);
    int sz[3], u[3], c[3], nest[3], t, skp;
    longint r;
    if (w == 0) return s;
    sz[0] = int'(w[5:0]) + 1; sz[1] = int'(w[11:6]) + 1; sz[2] = int'(w[17:12]) + 1;
    case (w[20:18])
      3'd0: nest = '{0, 1, 2};
      3'd1: nest = '{0, 2, 1};
      3'd2: nest = '{1, 0, 2};
      3'd3: nest = '{1, 2, 0};
      3'd4: nest = '{2, 0, 1};
      default: nest = '{2, 1, 0};
    endcase
    t = s;
    for (int k = 0; k < 3; k++) begin
      u[nest[k]] = t % sz[nest[k]];
      t = t / sz[nest[k]];
    end
    for (int d = 0; d < 3; d++) c[d] = w[21+d] ? (sz[d] - 1 - u[d]) : u[d];
    skp = int'(w[29:28]);
    case (skp)
      1: r = c[1] + c[2] * sz[1];
      2: r = c[0] + c[2] * sz[0];
      3: r = c[0] + c[1] * sz[0];
      default: r = c[0] + c[1] * sz[0] + c[2] * sz[0] * sz[1];
    endcase
    return r + int'(w[27:24]);
  endfunction

  task automatic load(input logic [31:0] w, input int len);
    shape_load = 1'b1; shape_word = w; walk_len = 7'(len);
    @(negedge clk);
    shape_load = 1'b0;
  endtask

  task automatic walk(input logic [31:0] w, input int len, input string req);
    load(w, len);
    for (int s = 0; s < len; s++) begin
      chk({req, " valid"}, idx_valid, 1);
      chk(req, idx, model(w, s));
      step = 1'b1;
      @(negedge clk);
    end
    step = 1'b0;
    chk("R8 done pulse", walk_done, 1);
    chk("R8 valid drop", idx_valid, 0);
    @(negedge clk);
    chk("R8 done single", walk_done, 0);
  endtask

  initial begin
    logic [31:0] wa, wb;
    repeat (3) @(negedge clk);
    chk("R1 valid", idx_valid, 0);
    chk("R1 done", walk_done, 0);
    chk("R1 err", shape_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", idx_valid, 0);

    walk(mk(3, 2, 2, 0, 0, 0, 0), 12, "R2");
    walk(mk(4, 3, 1, 0, 0, 0, 0), 12, "R2");
    walk(mk(3, 2, 2, 2, 0, 0, 0), 12, "R3");
    walk(mk(3, 2, 2, 0, 5, 0, 0), 12, "R4");
    walk(mk(3, 2, 2, 0, 0, 0, 1), 12, "R5");
    walk(mk(3, 3, 2, 0, 0, 0, 3), 18, "R5");
    walk(mk(3, 2, 2, 4, 0, 9, 0), 12, "R6");
    walk(32'h0, 127, "R7");
    walk(mk(2, 1, 1, 0, 0, 0, 0), 1, "R8");

    for (int o = 0; o < 6; o++)
      for (int v = 0; v < 8; v++)
        for (int k = 0; k < 4; k++)
          walk(mk(3, 2, 2, o, v, (o + v + k) % 16, k), 12, "R3");
    for (int o = 0; o < 6; o++)
      for (int k = 0; k < 4; k++) begin
        walk(mk(2, 3, 4, o, 0, k, k), 30, "R3");
        walk(mk(2, 3, 4, o, 7, 15 - k, k), 30, "R4");
      end

    // R8: zero length stays idle
    load(32'h0, 0);
    chk("R8 zero len valid", idx_valid, 0);
    step = 1'b1;
    repeat (3) @(negedge clk);
    step = 1'b0;
    chk("R8 zero len done", walk_done, 0);

    // R9: malformed words
    load(mk(3, 2, 2, 6, 0, 0, 0), 12);
    chk("R9 order6 err", shape_err, 1);
    chk("R9 order6 valid", idx_valid, 0);
    load(mk(3, 2, 2, 7, 0, 0, 0), 12);
    chk("R9 order7 err", shape_err, 1);
    load(mk(3, 2, 2, 1, 0, 0, 0) | 32'h4000_0000, 12);
    chk("R9 mode err", shape_err, 1);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk("R9 no done", walk_done, 0);
    load(mk(3, 2, 2, 1, 0, 0, 0), 12);
    chk("R9 err cleared", shape_err, 0);
    chk("R9 valid ok", idx_valid, 1);

    // R11: hold with step low, then R10 restart with step held high
    wa = mk(3, 2, 2, 3, 2, 1, 0);
    wb = mk(4, 2, 3, 5, 1, 2, 2);
    load(wa, 12);
    step = 1'b1;
    repeat (5) @(negedge clk);
    step = 1'b0;
    chk("R11 pos", idx, model(wa, 5));
    repeat (3) @(negedge clk);
    chk("R11 hold", idx, model(wa, 5));
    chk("R11 valid", idx_valid, 1);
    step = 1'b1;
    @(negedge clk);
    chk("R11 resume", idx, model(wa, 6));
    shape_load = 1'b1; shape_word = wb; walk_len = 7'd24;
    @(negedge clk);
    shape_load = 1'b0;
    chk("R10 restart idx", idx, model(wb, 0));
    chk("R10 no done", walk_done, 0);
    for (int s = 1; s < 24; s++) begin
      @(negedge clk);
      chk("R10 walk", idx, model(wb, s));
    end
    @(negedge clk);
    step = 1'b0;
    chk("R10 done", walk_done, 1);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule